// File: doc/BRIEF.md
# DRAM Bank Command Order Monitor

This block sits beside a DRAM command bus and watches every command issued to the memory. For each bank it keeps the most recent command and whether the bank's row buffer is currently open. Each new command is checked against two rules. The first rule is that the command must be a permitted successor of the bank's previous command. The second rule is that the command must find the row in the state it needs. The block models only the all-bank refresh scheme. It checks no timing distances and does not look at the data bus.

Precharge-all and refresh are broadcast commands: whatever bank index comes with them, every bank checks them and every bank records them. All other commands affect only the bank they name. When the first violation occurs, the block raises a sticky error flag and latches a reason code and the offending bank. Later violations leave these latched values as they are. Only a reset clears them.

The block contains three pieces. A per-bank tracker holds the history for each bank. A priority picker selects which failing bank to report. A two-state supervisor (WATCH and TRIPPED) owns the error outputs. In WATCH, a detected violation takes the transition "trip" into TRIPPED. TRIPPED has only the transition "hold", back to itself, and stays there until reset.

Top module: `dram_seq_check`

## Requirements
- R1: After reset, the flag is 0, err_code is 0 and err_bank is 0. Every bank starts with a closed row and a previous command of PRE, so the first command on any bank is checked against that history. Command encoding: 0 ACT, 1 RD, 2 RDA, 3 WR, 4 WRA, 5 PRE, 6 PREA (precharge all), 7 REFA (refresh all), 8 PDNA (active power-down), 9 PDNP (precharge power-down), 10 SREF (self-refresh). Codes 11 to 15 are undefined.
- R2: Each command must be a permitted successor of the previous command of each bank it reaches. After PRE, the permitted commands are ACT and PREA. After PREA, only REFA is permitted. After ACT, the permitted commands are RD, RDA, WR, WRA and PREA. After RD or WR, the permitted commands are RD, RDA, WR, WRA, PRE, PREA and PDNA. After RDA or WRA, the permitted commands are ACT, PREA, REFA, PDNA and PDNP. After REFA, the permitted commands are ACT, PREA, REFA, PDNA, PDNP and SREF. After PDNP or SREF, the permitted commands are ACT, PREA, REFA, PDNA and PDNP. After PDNA, the permitted commands are ACT, RD, RDA, WR, WRA, PRE, PREA, REFA, PDNA and PDNP. A violation of this rule reports err_code 1.
- R3: RD, RDA, WR, WRA and PRE need an open row. ACT, PDNP, REFA and SREF need a closed row. A violation of this rule reports err_code 2.
- R4: ACT opens the bank's row. PRE, PREA, RDA and WRA close it. The history is updated even when the command itself was a violation.
- R5: PREA and REFA reach every bank regardless of cmd_bank. They are checked against every bank's history and recorded in every bank.
- R6: The error outputs appear on the clock edge that samples the offending command. They then stay frozen until reset.
- R7: An undefined command code reports err_code 3, with err_bank equal to the cmd_bank field.
- R8: While cmd_valid is 0, the command and bank inputs have no effect on any bank.
- R9: When one command fails in several banks, an order violation in any bank outranks a row violation. Within the same class, the lowest bank index is reported. A command sent to one bank leaves the other banks' histories unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd | input | 4 | Command code (encoding in R1) |
| cmd_bank | input | BANK_W (3) | Target bank; ignored for PREA and REFA |
| err_flag | output | 1 | Sticky violation flag |
| err_code | output | 2 | 0 none, 1 order, 2 row state, 3 undefined command |
| err_bank | output | BANK_W (3) | Bank of the first violation |

## Verification
The bench attacks the broadcast path in two ways. It sends a precharge-all with a non-zero bank field and then shows that a previously opened bank can accept a fresh activate. It also arranges a refresh that fails in two banks at once. A design that routed broadcasts only to the named bank would raise a false order error, and a design with the wrong scan direction would report the higher bank. One scenario puts a row-state fault in a low bank and an order fault in a higher bank for the same refresh, so a picker that ignored the class ranking would report the wrong bank and code. Other scenarios check the following. A read after active power-down with a closed row must give a row error rather than an order error. A second violation must not overwrite the first. Commands presented with cmd_valid low must leave the history untouched.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

    localparam int CMD_W = 4;

    typedef enum logic [CMD_W-1:0] {
        C_ACT  = 4'd0,
        C_RD   = 4'd1,
        C_RDA  = 4'd2,
        C_WR   = 4'd3,
        C_WRA  = 4'd4,
        C_PRE  = 4'd5,
        C_PREA = 4'd6,
        C_REFA = 4'd7,
        C_PDNA = 4'd8,
        C_PDNP = 4'd9,
        C_SREF = 4'd10
    } cmd_e;

    localparam logic [CMD_W-1:0] CMD_MAX = 4'd10;

    typedef enum logic [1:0] {
        E_NONE  = 2'd0,
        E_ORDER = 2'd1,
        E_ROW   = 2'd2,
        E_UNDEF = 2'd3
    } err_e;

    function automatic logic [15:0] bit_of(cmd_e c);
        return 16'(1) << c;
    endfunction

    // set of commands permitted after 'last'
    function automatic logic [15:0] succ_mask(cmd_e last);
        logic [15:0] m;
        case (last)
            C_PRE:        m = bit_of(C_ACT) | bit_of(C_PREA);
            C_PREA:       m = bit_of(C_REFA);
            C_ACT:        m = bit_of(C_RD) | bit_of(C_RDA) | bit_of(C_WR) | bit_of(C_WRA) | bit_of(C_PREA);
            C_RD, C_WR:   m = bit_of(C_RD) | bit_of(C_RDA) | bit_of(C_WR) | bit_of(C_WRA)
                            | bit_of(C_PRE) | bit_of(C_PREA) | bit_of(C_PDNA);
            C_RDA, C_WRA: m = bit_of(C_ACT) | bit_of(C_PREA) | bit_of(C_REFA) | bit_of(C_PDNA) | bit_of(C_PDNP);
            C_REFA:       m = bit_of(C_ACT) | bit_of(C_PREA) | bit_of(C_REFA) | bit_of(C_PDNA)
                            | bit_of(C_PDNP) | bit_of(C_SREF);
            C_PDNA:       m = bit_of(C_ACT) | bit_of(C_RD) | bit_of(C_RDA) | bit_of(C_WR) | bit_of(C_WRA)
                            | bit_of(C_PRE) | bit_of(C_PREA) | bit_of(C_REFA) | bit_of(C_PDNA) | bit_of(C_PDNP);
            C_PDNP, C_SREF: m = bit_of(C_ACT) | bit_of(C_PREA) | bit_of(C_REFA) | bit_of(C_PDNA) | bit_of(C_PDNP);
            default:      m = '0;
        endcase
        return m;
    endfunction

    function automatic logic needs_open(cmd_e c);
        return (c == C_RD) || (c == C_RDA) || (c == C_WR) || (c == C_WRA) || (c == C_PRE);
    endfunction

    function automatic logic needs_closed(cmd_e c);
        return (c == C_ACT) || (c == C_PDNP) || (c == C_REFA) || (c == C_SREF);
    endfunction

endpackage

// File: rtl/dseq_bank_tracker.sv
module dseq_bank_tracker
    import dseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  cmd_e op,
    output logic seq_bad,
    output logic row_bad,
    output logic row_open
);

    typedef enum logic {ROW_CLOSED, ROW_OPEN} row_e;

    row_e        row_q;
    cmd_e        last_q;
    logic [15:0] allowed;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q  <= ROW_CLOSED;
            last_q <= C_PRE;
        end else if (hit) begin
            last_q <= op;
            case (op)
                C_ACT:                      row_q <= ROW_OPEN;
                C_PRE, C_PREA, C_RDA, C_WRA: row_q <= ROW_CLOSED;
                default:                    row_q <= row_q;
            endcase
        end
    end

    always_comb begin
        allowed  = succ_mask(last_q);
        seq_bad  = hit && !allowed[op];
        row_bad  = hit && ((needs_open(op) && row_q == ROW_CLOSED) ||
                           (needs_closed(op) && row_q == ROW_OPEN));
        row_open = (row_q == ROW_OPEN);
    end

endmodule

// File: rtl/dseq_fault_pick.sv
module dseq_fault_pick
    import dseq_pkg::*;
#(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  seq_bad,
    input  logic [N-1:0]  row_bad,
    output logic          any,
    output err_e          code,
    output logic [IW-1:0] idx
);

    always_comb begin
        any  = (|seq_bad) || (|row_bad);
        code = E_NONE;
        idx  = '0;
        if (|seq_bad) begin
            code = E_ORDER;
            for (int i = N - 1; i >= 0; i--)
                if (seq_bad[i]) idx = IW'(i);
        end else if (|row_bad) begin
            code = E_ROW;
            for (int i = N - 1; i >= 0; i--)
                if (row_bad[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/dram_seq_check.sv
module dram_seq_check
    import dseq_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd,
    input  logic [BANK_W-1:0] cmd_bank,
    output logic              err_flag,
    output logic [1:0]        err_code,
    output logic [BANK_W-1:0] err_bank
);

    typedef enum logic {ST_WATCH, ST_TRIPPED} state_e;

    state_e              state_q, state_d;
    err_e                code_q;
    logic [BANK_W-1:0]   bank_q;

    logic                undef_cmd;
    logic                broadcast;
    cmd_e                op;
    logic [NUM_BANKS-1:0] seq_bad_vec, row_bad_vec, row_open_vec;
    logic                pick_any;
    err_e                pick_code;
    logic [BANK_W-1:0]   pick_idx;
    logic                detect;
    err_e                code_now;
    logic [BANK_W-1:0]   bank_now;

    assign undef_cmd = cmd > CMD_MAX;
    assign op        = cmd_e'(cmd);
    assign broadcast = (op == C_PREA) || (op == C_REFA);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit_b;
        assign hit_b = cmd_valid && !undef_cmd && (broadcast || cmd_bank == BANK_W'(b));
        dseq_bank_tracker u_trk (
            .clk      (clk),
            .rst_n    (rst_n),
            .hit      (hit_b),
            .op       (op),
            .seq_bad  (seq_bad_vec[b]),
            .row_bad  (row_bad_vec[b]),
            .row_open (row_open_vec[b])
        );
    end

    dseq_fault_pick #(.N(NUM_BANKS), .IW(BANK_W)) u_pick (
        .seq_bad (seq_bad_vec),
        .row_bad (row_bad_vec),
        .any     (pick_any),
        .code    (pick_code),
        .idx     (pick_idx)
    );

    always_comb begin
        detect   = cmd_valid && (undef_cmd || pick_any);
        code_now = undef_cmd ? E_UNDEF : pick_code;
        bank_now = undef_cmd ? cmd_bank : pick_idx;
        state_d  = state_q;
        unique case (state_q)
            ST_WATCH:   if (detect) state_d = ST_TRIPPED;  // trip
            ST_TRIPPED: state_d = ST_TRIPPED;              // hold
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WATCH;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= E_NONE;
            bank_q <= '0;
        end else if (state_q == ST_WATCH && detect) begin
            code_q <= code_now;
            bank_q <= bank_now;
        end
    end

    assign err_flag = (state_q == ST_TRIPPED);
    assign err_code = code_q;
    assign err_bank = bank_q;

endmodule

// File: rtl/dram_seq_check_sva.sv
module dram_seq_check_sva #(
    parameter int NUM_BANKS = 8,
    parameter int BANK_W    = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_valid,
    input logic [3:0]           cmd,
    input logic [BANK_W-1:0]    cmd_bank,
    input logic                 err_flag,
    input logic [1:0]           err_code,
    input logic [BANK_W-1:0]    err_bank,
    input logic [NUM_BANKS-1:0] row_open
);

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> ($stable(err_code) && $stable(err_bank)));

    p_flag_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag == (err_code != 2'd0));

    p_prea_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd == 4'd6) |=> (row_open == '0));

    p_act_opens_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd == 4'd0) |=>
            ((row_open & (NUM_BANKS'(1) << $past(cmd_bank))) != '0));

    p_undef_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd > 4'd10 && !err_flag) |=> (err_flag && err_code == 2'd3));

endmodule

bind dram_seq_check dram_seq_check_sva #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) i_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd       (cmd),
    .cmd_bank  (cmd_bank),
    .err_flag  (err_flag),
    .err_code  (err_code),
    .err_bank  (err_bank),
    .row_open  (row_open_vec)
);

// File: tb/test_dram_seq_check.sv
module test_dram_seq_check;

    localparam int ACT = 0, RD = 1, RDA = 2, WR = 3, WRA = 4, PRE = 5;
    localparam int PREA = 6, REFA = 7, PDNA = 8, PDNP = 9, SREF = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_valid;
    logic [3:0] cmd;
    logic [2:0] cmd_bank;
    logic       err_flag;
    logic [1:0] err_code;
    logic [2:0] err_bank;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    dram_seq_check i_dram_seq_check (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .cmd_bank  (cmd_bank),
        .err_flag  (err_flag),
        .err_code  (err_code),
        .err_bank  (err_bank)
    );

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cmd_valid = 1'b0; cmd = '0; cmd_bank = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic issue(input int c, input int b);
        cmd_valid = 1'b1; cmd = 4'(c); cmd_bank = 3'(b);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic expect_out(input string tag, input int f, input int c, input int b);
        n_checks++;
        if (int'(err_flag) != f || int'(err_code) != c || int'(err_bank) != b) begin
            n_fail++;
            $display("FAIL %s: flag/code/bank got %0d/%0d/%0d expected %0d/%0d/%0d",
                     tag, err_flag, err_code, err_bank, f, c, b);
        end
    endtask

    task automatic t_reset();
        do_reset();
        expect_out("R1 reset state", 0, 0, 0);
        issue(ACT, 0);
        expect_out("R1 ACT legal from reset history", 0, 0, 0);
    endtask

    task automatic t_legal_flow();
        do_reset();
        issue(ACT, 2); issue(RD, 2); issue(WR, 2); issue(RDA, 2);
        issue(PDNP, 2); issue(ACT, 2); issue(WRA, 2); issue(ACT, 2);
        issue(RD, 2); issue(PRE, 2);
        expect_out("R2 R4 legal open/close flow", 0, 0, 0);
        issue(ACT, 2);
        expect_out("R4 PRE closed row", 0, 0, 0);
    endtask

    task automatic t_order();
        do_reset();
        issue(RD, 5);
        expect_out("R2 R9 RD after PRE order beats row", 1, 1, 5);
        do_reset();
        issue(ACT, 1); issue(ACT, 1);
        expect_out("R2 ACT after ACT", 1, 1, 1);
    endtask

    task automatic t_row();
        do_reset();
        issue(ACT, 4); issue(RDA, 4); issue(PDNA, 4);
        expect_out("R3 legal so far", 0, 0, 0);
        issue(RD, 4);
        expect_out("R3 RD on closed row after PDNA", 1, 2, 4);
    endtask

    task automatic t_broadcast();
        do_reset();
        issue(ACT, 1); issue(PREA, 3); issue(REFA, 6); issue(ACT, 1); issue(SREF, 0);
        expect_out("R5 PREA/REFA reach all banks", 0, 0, 0);
        issue(ACT, 3); issue(ACT, 6);
        expect_out("R9 other banks untouched", 0, 0, 0);
        issue(REFA, 5);
        expect_out("R5 REFA fails lowest bank", 1, 1, 1);
    endtask

    task automatic t_sticky();
        do_reset();
        issue(RD, 5);
        issue(13, 2);
        issue(ACT, 3); issue(ACT, 3);
        expect_out("R6 first error kept", 1, 1, 5);
        do_reset();
        expect_out("R6 reset clears", 0, 0, 0);
    endtask

    task automatic t_undef();
        do_reset();
        issue(14, 6);
        expect_out("R7 undefined code", 1, 3, 6);
    endtask

    task automatic t_idle();
        do_reset();
        cmd_valid = 1'b0; cmd = 4'(RD); cmd_bank = 3'd5;
        repeat (3) @(negedge clk);
        cmd = 4'(15);
        @(negedge clk);
        expect_out("R8 idle inputs ignored", 0, 0, 0);
        issue(ACT, 5);
        expect_out("R8 history unchanged", 0, 0, 0);
    endtask

    task automatic t_priority();
        do_reset();
        issue(PREA, 0); issue(REFA, 0);
        issue(ACT, 1); issue(RD, 1); issue(PDNA, 1);
        issue(ACT, 3);
        expect_out("R9 setup legal", 0, 0, 0);
        issue(REFA, 0);
        expect_out("R9 order in bank3 beats row in bank1", 1, 1, 3);
    endtask

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd = '0; cmd_bank = '0;
        t_reset();
        t_legal_flow();
        t_order();
        t_row();
        t_broadcast();
        t_sticky();
        t_undef();
        t_idle();
        t_priority();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule